// File: doc/BRIEF.md
# Store-and-Forward Packet FIFO

This block is a single-clock packet buffer. It sits between a client stream source and an Ethernet transmit or receive path. Both sides use a 64-bit word with a valid/ready handshake. Each word carries start and end of packet markers, a 3-bit count of unused bytes on the closing word, and an error flag. Every stored entry keeps the data, both markers, the empty count and the error bit, so the output carries exactly the same framing as the input.

In store-and-forward mode (`sf_mode` = 1) a frame becomes visible at the output only after its closing word has been written. A frame that carries an error on any of its words is removed from the buffer without trace. A frame that meets a full buffer partway through is also removed: its remaining words are swallowed and a sticky overflow flag is set. In cut-through mode (`sf_mode` = 0) each word is visible one cycle after it is written. Errored frames then pass through with their error bit, and a full buffer holds the source back. The occupancy of the buffer is reported every cycle. `sf_mode` is expected to change only while the buffer is empty and no frame is in flight.

The write side is a three-state machine:
- **WR_IDLE** waits for a start-of-packet word. A single-word frame stays in WR_IDLE, and so does a word without start of packet, which is discarded. A start word that does not also close the frame moves to WR_FRAME.
- **WR_FRAME** stores the words of a frame. The closing word returns to WR_IDLE, where the frame is either committed or rewound.
- **WR_DROP** is entered from WR_FRAME when a store-and-forward frame hits a full buffer. It swallows words until end of packet, then returns to WR_IDLE.

Top module: `sf_packet_fifo`

## Requirements
- R1: After reset `out_valid` is 0, `fill_level` is 0, `overflow` is 0 and `in_ready` is 1.
- R2: In store-and-forward mode no word of a frame is presented before its end-of-packet word is accepted. `out_valid` rises in the cycle after that acceptance.
- R3: Output words appear in input order with identical data, sop, eop and empty values. Empty is the number of unused bytes in the eop word.
- R4: In store-and-forward mode a frame whose eop word carries error is never presented. One cycle after that word, `fill_level` is back to its value before the frame, and `out_error` is never 1 while `out_valid` is 1.
- R5: In store-and-forward mode an error on any earlier word of a frame also drops the whole frame, even when its eop word is clean.
- R6: An accepted word without sop, arriving while no frame is open, is discarded and not stored.
- R7: In store-and-forward mode, a frame word that arrives while the buffer is full drops the frame and sets `overflow`. The rest of that frame, up to eop, is accepted with `in_ready` high and discarded. `overflow` stays set until reset.
- R8: In store-and-forward mode, with no frame open, `in_ready` is 0 while the buffer is full.
- R9: In cut-through mode a word is presented in the cycle after it is written. Errored frames are forwarded, with `out_error` equal to the input error bit of each word.
- R10: In cut-through mode `in_ready` is 0 whenever the buffer is full, and `overflow` never sets.
- R11: `fill_level` equals the number of stored entries, including words of a frame not yet released. It changes in the cycle after each write or read and never exceeds DEPTH.
- R12: While `out_valid` is 1 and `out_ready` is 0, the output word stays valid and unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sf_mode | input | 1 | 1 = store-and-forward, 0 = cut-through |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Buffer accepts the input word |
| in_data | input | DATA_W | Input data |
| in_sop | input | 1 | Input start of packet |
| in_eop | input | 1 | Input end of packet |
| in_empty | input | EMPTY_W | Unused bytes in the eop word |
| in_error | input | 1 | Input word error |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer accepts the output word |
| out_data | output | DATA_W | Output data |
| out_sop | output | 1 | Output start of packet |
| out_eop | output | 1 | Output end of packet |
| out_empty | output | EMPTY_W | Unused bytes in the eop word |
| out_error | output | 1 | Output word error (cut-through only) |
| fill_level | output | LVL_W | Occupied entries |
| overflow | output | 1 | Sticky frame-dropped-on-full flag |

## Verification
The failures that matter show up in the pointers. A wrongly placed commit pointer shows at the output in the very next cycle: `out_valid` rises before eop, or a dropped frame's words appear. A rewind to the wrong place shows as `fill_level` not returning to its earlier value one cycle after the bad eop. It also shows later as stray or missing words when the buffer is drained. A write state machine stuck in the wrong state shows as `in_ready` held high against a full buffer, or as a following good frame being swallowed. Either is visible within the next frame.

// File: rtl/sf_fifo_pkg.sv
package sf_fifo_pkg;
    typedef enum logic [1:0] {
        WR_IDLE  = 2'd0,
        WR_FRAME = 2'd1,
        WR_DROP  = 2'd2
    } wr_state_e;
endpackage

// File: rtl/sf_fifo_store.sv
module sf_fifo_store #(
    parameter int WIDTH = 70,
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_word,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_word
);
    logic [WIDTH-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[wr_addr] <= wr_word;
        end
    end

    assign rd_word = cells[rd_addr];
endmodule

// File: rtl/sf_fifo_wr_ctl.sv
module sf_fifo_wr_ctl
    import sf_fifo_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int PW = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sf_mode,
    input  logic          in_valid,
    input  logic          in_sop,
    input  logic          in_eop,
    input  logic          in_error,
    input  logic [PW-1:0] rd_ptr,
    output logic          in_ready,
    output logic          mem_we,
    output logic [PW-1:0] wr_ptr,
    output logic [PW-1:0] commit_ptr,
    output logic          overflow
);
    wr_state_e     st, st_n;
    logic [PW-1:0] wr_n, cm_n;
    logic          bad, bad_n, ovf_n;
    logic [PW-1:0] used;
    logic          full;

    assign used = wr_ptr - rd_ptr;
    assign full = (used == PW'(DEPTH));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st         <= WR_IDLE;
            wr_ptr     <= '0;
            commit_ptr <= '0;
            bad        <= 1'b0;
            overflow   <= 1'b0;
        end else begin
            st         <= st_n;
            wr_ptr     <= wr_n;
            commit_ptr <= cm_n;
            bad        <= bad_n;
            overflow   <= ovf_n;
        end
    end

    // next state and outputs
    always_comb begin
        st_n     = st;
        wr_n     = wr_ptr;
        cm_n     = commit_ptr;
        bad_n    = bad;
        ovf_n    = overflow;
        in_ready = 1'b0;
        mem_we   = 1'b0;
        unique case (st)
            WR_IDLE: begin
                in_ready = !full;
                if (in_valid && !full && in_sop) begin
                    mem_we = 1'b1;
                    wr_n   = wr_ptr + 1'b1;
                    if (in_eop) begin
                        if (sf_mode && in_error) begin
                            wr_n = commit_ptr;
                        end else begin
                            cm_n = wr_ptr + 1'b1;
                        end
                    end else begin
                        st_n  = WR_FRAME;
                        bad_n = in_error;
                        if (!sf_mode) begin
                            cm_n = wr_ptr + 1'b1;
                        end
                    end
                end
            end
            WR_FRAME: begin
                in_ready = sf_mode ? 1'b1 : !full;
                if (in_valid && in_ready) begin
                    if (full) begin
                        // only reachable in store-and-forward mode
                        wr_n  = commit_ptr;
                        ovf_n = 1'b1;
                        bad_n = 1'b0;
                        st_n  = in_eop ? WR_IDLE : WR_DROP;
                    end else begin
                        mem_we = 1'b1;
                        wr_n   = wr_ptr + 1'b1;
                        if (!sf_mode) begin
                            cm_n = wr_ptr + 1'b1;
                        end
                        if (in_eop) begin
                            st_n  = WR_IDLE;
                            bad_n = 1'b0;
                            if (sf_mode) begin
                                if (bad || in_error) begin
                                    wr_n = commit_ptr;
                                end else begin
                                    cm_n = wr_ptr + 1'b1;
                                end
                            end
                        end else begin
                            bad_n = bad | in_error;
                        end
                    end
                end
            end
            WR_DROP: begin
                in_ready = 1'b1;
                if (in_valid && in_eop) begin
                    st_n = WR_IDLE;
                end
            end
            default: begin
                st_n = WR_IDLE;
            end
        endcase
    end
endmodule

// File: rtl/sf_fifo_rd_ctl.sv
module sf_fifo_rd_ctl #(
    parameter int DEPTH = 64,
    localparam int PW = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] wr_ptr,
    input  logic [PW-1:0] commit_ptr,
    input  logic          out_ready,
    output logic          out_valid,
    output logic [PW-1:0] rd_ptr,
    output logic [PW-1:0] fill_level
);
    assign out_valid  = (rd_ptr != commit_ptr);
    assign fill_level = wr_ptr - rd_ptr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
        end else if (out_valid && out_ready) begin
            rd_ptr <= rd_ptr + 1'b1;
        end
    end
endmodule

// File: rtl/sf_packet_fifo.sv
module sf_packet_fifo #(
    parameter int DATA_W = 64,
    parameter int DEPTH  = 64,
    localparam int EMPTY_W = $clog2(DATA_W / 8),
    localparam int LVL_W   = $clog2(DEPTH) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sf_mode,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [DATA_W-1:0]  in_data,
    input  logic               in_sop,
    input  logic               in_eop,
    input  logic [EMPTY_W-1:0] in_empty,
    input  logic               in_error,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [DATA_W-1:0]  out_data,
    output logic               out_sop,
    output logic               out_eop,
    output logic [EMPTY_W-1:0] out_empty,
    output logic               out_error,
    output logic [LVL_W-1:0]   fill_level,
    output logic               overflow
);
    localparam int AW      = $clog2(DEPTH);
    localparam int ENTRY_W = DATA_W + EMPTY_W + 3;

    logic [LVL_W-1:0]   wr_ptr, commit_ptr, rd_ptr;
    logic               mem_we;
    logic [ENTRY_W-1:0] wr_word, rd_word;

    assign wr_word = {in_error, in_sop, in_eop, in_empty, in_data};
    assign {out_error, out_sop, out_eop, out_empty, out_data} = rd_word;

    sf_fifo_wr_ctl #(.DEPTH(DEPTH)) u_wr (
        .clk        (clk),
        .rst_n      (rst_n),
        .sf_mode    (sf_mode),
        .in_valid   (in_valid),
        .in_sop     (in_sop),
        .in_eop     (in_eop),
        .in_error   (in_error),
        .rd_ptr     (rd_ptr),
        .in_ready   (in_ready),
        .mem_we     (mem_we),
        .wr_ptr     (wr_ptr),
        .commit_ptr (commit_ptr),
        .overflow   (overflow)
    );

    sf_fifo_rd_ctl #(.DEPTH(DEPTH)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ptr     (wr_ptr),
        .commit_ptr (commit_ptr),
        .out_ready  (out_ready),
        .out_valid  (out_valid),
        .rd_ptr     (rd_ptr),
        .fill_level (fill_level)
    );

    sf_fifo_store #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .wr_en   (mem_we),
        .wr_addr (wr_ptr[AW-1:0]),
        .wr_word (wr_word),
        .rd_addr (rd_ptr[AW-1:0]),
        .rd_word (rd_word)
    );
endmodule

// File: rtl/sf_packet_fifo_chk.sv
module sf_packet_fifo_chk #(
    parameter int DATA_W  = 64,
    parameter int DEPTH   = 64,
    parameter int EMPTY_W = 3,
    parameter int LVL_W   = 7
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sf_mode,
    input logic               in_ready,
    input logic               out_valid,
    input logic               out_ready,
    input logic [DATA_W-1:0]  out_data,
    input logic               out_sop,
    input logic               out_eop,
    input logic [EMPTY_W-1:0] out_empty,
    input logic               out_error,
    input logic [LVL_W-1:0]   fill_level,
    input logic               overflow
);
    assert_idle_out_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_level == '0) |-> !out_valid);

    assert_clean_out_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sf_mode && out_valid) |-> !out_error);

    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    assert_ct_backpressure_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!sf_mode && fill_level == LVL_W'(DEPTH)) |-> !in_ready);

    assert_fill_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fill_level <= LVL_W'(DEPTH));

    assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sop)
            && $stable(out_eop) && $stable(out_empty) && $stable(out_error)));
endmodule

bind sf_packet_fifo sf_packet_fifo_chk #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .EMPTY_W(EMPTY_W), .LVL_W(LVL_W)
) u_chk (.*);

// File: tb/test_sf_packet_fifo.sv
`timescale 1ns/1ps
module test_sf_packet_fifo;
    localparam int DEPTH = 64;
    localparam int LW    = $clog2(DEPTH) + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sf_mode = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] in_data = '0;
    logic        in_sop = 1'b0, in_eop = 1'b0, in_error = 1'b0;
    logic [2:0]  in_empty = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [63:0] out_data;
    logic        out_sop, out_eop, out_error;
    logic [2:0]  out_empty;
    logic [LW-1:0] fill_level;
    logic        overflow;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [63:0] e_data [256];
    logic        e_sop [256], e_eop [256], e_err [256];
    logic [2:0]  e_emp [256];
    int          e_wr = 0, e_rd = 0;

    always #2.5 clk = ~clk;

    sf_packet_fifo #(.DATA_W(64), .DEPTH(DEPTH)) i_sf_packet_fifo (
        .clk(clk), .rst_n(rst_n), .sf_mode(sf_mode),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_sop(in_sop), .in_eop(in_eop), .in_empty(in_empty), .in_error(in_error),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_sop(out_sop), .out_eop(out_eop), .out_empty(out_empty), .out_error(out_error),
        .fill_level(fill_level), .overflow(overflow)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    // output monitor: compares every accepted word with the model (R3, R9)
    always @(negedge clk) begin
        #1;
        if (rst_n && out_valid && out_ready) begin
            if (e_rd == e_wr) begin
                check(1'b0, "R3", "unexpected output word", out_data, 0);
            end else begin
                check(out_data == e_data[e_rd % 256], "R3", "data", out_data, e_data[e_rd % 256]);
                check({out_sop, out_eop, out_empty} == {e_sop[e_rd % 256], e_eop[e_rd % 256], e_emp[e_rd % 256]},
                      "R3", "sop/eop/empty", {out_sop, out_eop, out_empty},
                      {e_sop[e_rd % 256], e_eop[e_rd % 256], e_emp[e_rd % 256]});
                check(out_error == e_err[e_rd % 256], "R9", "error bit", out_error, e_err[e_rd % 256]);
                e_rd++;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", "run did not finish", 0, 1);
        report();
    end

    task automatic expect_word(input logic [63:0] d, input logic s, input logic e,
                               input logic [2:0] m, input logic er);
        e_data[e_wr % 256] = d; e_sop[e_wr % 256] = s; e_eop[e_wr % 256] = e;
        e_emp[e_wr % 256] = m;  e_err[e_wr % 256] = er;
        e_wr++;
    endtask

    // drive one word, called at a falling edge; returns at the falling edge after acceptance
    task automatic put(input logic [63:0] d, input logic s, input logic e,
                       input logic [2:0] m, input logic er);
        logic took;
        in_data = d; in_sop = s; in_eop = e; in_empty = m; in_error = er;
        in_valid = 1'b1;
        took = 1'b0;
        while (!took) begin
            #1;
            took = in_ready;
            @(negedge clk);
        end
    endtask

    task automatic idle_in();
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_error = 1'b0;
    endtask

    function automatic logic [63:0] word_of(input int tag, input int idx);
        return {16'hB0C5, tag[15:0], 16'h5A00, idx[15:0]};
    endfunction

    task automatic send_frame(input int tag, input int n, input int bad_at,
                              input bit keep, input logic [2:0] m);
        for (int i = 0; i < n; i++) begin
            logic s, e, er;
            logic [2:0] mm;
            s = (i == 0); e = (i == n - 1); er = (i == bad_at);
            mm = e ? m : 3'd0;
            if (keep) expect_word(word_of(tag, i), s, e, mm, er);
            put(word_of(tag, i), s, e, mm, er);
        end
        idle_in();
    endtask

    task automatic drain(input string req);
        int spin;
        out_ready = 1'b1;
        spin = 0;
        while ((e_rd != e_wr || fill_level != '0) && spin < 3000) begin
            @(negedge clk);
            spin++;
        end
        @(negedge clk);
        out_ready = 1'b0;
        @(negedge clk);
        check(e_rd == e_wr, req, "all expected words delivered", e_rd, e_wr);
        check(fill_level == '0, "R11", "fill after drain", fill_level, 0);
    endtask

    task automatic do_reset();
        idle_in();
        out_ready = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        #1;
        check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        check(fill_level == '0, "R1", "fill after reset", fill_level, 0);
        check(overflow == 1'b0, "R1", "overflow after reset", overflow, 0);
        check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    endtask

    task automatic t_holdback();
        for (int i = 0; i < 3; i++) begin
            expect_word(word_of(1, i), i == 0, 1'b0, 3'd0, 1'b0);
            put(word_of(1, i), i == 0, 1'b0, 3'd0, 1'b0);
        end
        idle_in();
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R2", "valid before eop", out_valid, 0);
        check(fill_level == LW'(3), "R11", "fill of partial frame", fill_level, 3);
        expect_word(word_of(1, 3), 1'b0, 1'b1, 3'd5, 1'b0);
        put(word_of(1, 3), 1'b0, 1'b1, 3'd5, 1'b0);
        idle_in();
        check(out_valid == 1'b1, "R2", "valid cycle after eop", out_valid, 1);
        check(out_sop == 1'b1 && out_data == word_of(1, 0), "R12", "head word held", out_data, word_of(1, 0));
        drain("R3");
    endtask

    task automatic t_err_eop();
        send_frame(2, 2, -1, 1'b1, 3'd1);
        send_frame(3, 3, 2, 1'b0, 3'd0);
        check(fill_level == LW'(2), "R4", "fill reclaimed after bad eop", fill_level, 2);
        send_frame(4, 1, -1, 1'b1, 3'd7);
        drain("R4");
    endtask

    task automatic t_err_mid();
        send_frame(5, 4, 1, 1'b0, 3'd0);
        check(fill_level == '0, "R5", "fill after mid-frame error", fill_level, 0);
        check(out_valid == 1'b0, "R5", "no output of bad frame", out_valid, 0);
        send_frame(6, 2, -1, 1'b1, 3'd3);
        drain("R5");
    endtask

    task automatic t_stray();
        put(word_of(7, 0), 1'b0, 1'b0, 3'd0, 1'b0);
        put(word_of(7, 1), 1'b0, 1'b1, 3'd2, 1'b0);
        idle_in();
        @(negedge clk);
        check(fill_level == '0, "R6", "stray words not stored", fill_level, 0);
        send_frame(8, 2, -1, 1'b1, 3'd0);
        drain("R6");
    endtask

    task automatic t_sf_full();
        for (int f = 0; f < 4; f++) send_frame(10 + f, DEPTH / 4, -1, 1'b1, 3'd2);
        #1;
        check(fill_level == LW'(DEPTH), "R8", "fill when full", fill_level, DEPTH);
        check(in_ready == 1'b0, "R8", "ready low when full between frames", in_ready, 0);
        check(overflow == 1'b0, "R7", "no overflow on exact fit", overflow, 0);
        drain("R8");
    endtask

    task automatic t_overflow();
        for (int i = 0; i < DEPTH + 1; i++) begin
            put(word_of(20, i), i == 0, 1'b0, 3'd0, 1'b0);
        end
        #1;
        check(fill_level == '0, "R7", "truncated frame removed", fill_level, 0);
        check(overflow == 1'b1, "R7", "overflow set", overflow, 1);
        check(in_ready == 1'b1, "R7", "ready high while discarding", in_ready, 1);
        for (int i = DEPTH + 1; i < DEPTH + 5; i++) begin
            put(word_of(20, i), 1'b0, i == DEPTH + 4, 3'd0, 1'b0);
        end
        idle_in();
        @(negedge clk);
        check(fill_level == '0, "R7", "tail of frame discarded", fill_level, 0);
        send_frame(21, 2, -1, 1'b1, 3'd4);
        drain("R7");
        check(overflow == 1'b1, "R7", "overflow sticky", overflow, 1);
        do_reset();
        check(overflow == 1'b0, "R7", "overflow cleared by reset", overflow, 0);
    endtask

    task automatic t_cut_through();
        sf_mode = 1'b0;
        @(negedge clk);
        expect_word(word_of(30, 0), 1'b1, 1'b0, 3'd0, 1'b0);
        put(word_of(30, 0), 1'b1, 1'b0, 3'd0, 1'b0);
        idle_in();
        check(out_valid == 1'b1, "R9", "word visible next cycle", out_valid, 1);
        expect_word(word_of(30, 1), 1'b0, 1'b0, 3'd0, 1'b1);
        put(word_of(30, 1), 1'b0, 1'b0, 3'd0, 1'b1);
        expect_word(word_of(30, 2), 1'b0, 1'b1, 3'd6, 1'b0);
        put(word_of(30, 2), 1'b0, 1'b1, 3'd6, 1'b0);
        idle_in();
        send_frame(31, 2, 1, 1'b1, 3'd1);
        drain("R9");
    endtask

    task automatic t_ct_full();
        for (int i = 0; i < DEPTH; i++) begin
            expect_word(word_of(40, i), i == 0, 1'b0, 3'd0, 1'b0);
            put(word_of(40, i), i == 0, 1'b0, 3'd0, 1'b0);
        end
        idle_in();
        #1;
        check(fill_level == LW'(DEPTH), "R10", "fill when full", fill_level, DEPTH);
        check(in_ready == 1'b0, "R10", "ready low when full mid-frame", in_ready, 0);
        check(overflow == 1'b0, "R10", "no overflow in cut-through", overflow, 0);
        @(negedge clk);
        out_ready = 1'b1;
        expect_word(word_of(40, DEPTH), 1'b0, 1'b1, 3'd3, 1'b0);
        put(word_of(40, DEPTH), 1'b0, 1'b1, 3'd3, 1'b0);
        idle_in();
        drain("R10");
        check(overflow == 1'b0, "R10", "overflow still clear", overflow, 0);
    endtask

    initial begin
        do_reset();
        t_reset_state();
        t_holdback();
        t_err_eop();
        t_err_mid();
        t_stray();
        t_sf_full();
        t_overflow();
        t_cut_through();
        t_ct_full();
        report();
    end
endmodule